// File: doc/BRIEF.md
# Sliding Node Window with Indexed Reads

This block keeps a moving window over a stream of mesh node values. Values arrive in the order a space-filling curve visits the nodes, so node indices rise steadily. The producer writes them one per cycle at the tail of the window, and they come grouped in chunks of `CHUNK` consecutive indices. Compute stages read any node by its absolute index. A read returns the stored value with a hit flag when the index lies inside the window. Otherwise it returns a miss, and a separate buffer outside this block must serve that node.

The consumer frees storage one whole chunk at a time. It raises a release request when the lowest-indexed chunk is no longer needed. The window then advances its base by one chunk and frees those slots for new writes.

Node `i` always lives in storage slot `i mod DEPTH`, so the base index and the tail pointer wrap together. A three-state occupancy machine (`W_EMPTY`, `W_PARTIAL`, `W_FULL`) controls the write stall. It has these transitions:
- fill_start: `W_EMPTY` to `W_PARTIAL` on the first write.
- fill_top: `W_PARTIAL` to `W_FULL` when the count reaches `DEPTH`.
- drain_empty: `W_PARTIAL` to `W_EMPTY` when a release leaves nothing.
- release_from_full: `W_FULL` to `W_PARTIAL` on a release.

Top module: `swin_fifo`

## Requirements
- R1: After reset the window is empty with base index 0, `wr_ready` is 1, and every read reports a miss.
- R2: A write is accepted in a cycle where `wr_valid` and `wr_ready` are both 1. It stores `wr_data` as node `base + count`, and the count grows by one.
- R3: `wr_ready` is 0 while the window holds `DEPTH` (1024) words. A write offered then is dropped, and the count never exceeds `DEPTH`.
- R4: A read issued with `rd_valid` in one cycle gives `rd_out_valid` exactly one cycle later. When `base <= rd_index < base + count`, it returns `rd_hit = 1` and the stored value of that node.
- R5: A read whose index lies outside the window returns `rd_hit = 0` with `rd_data = 0`.
- R6: A release request while the count is at least `CHUNK` (16) advances the base by `CHUNK` and lowers the count by `CHUNK`. The released nodes then miss.
- R7: A release request while the count is below `CHUNK` is ignored: the base and the stored nodes stay unchanged.
- R8: A read of the node being written in the same cycle reports a miss. The same index hits from the next cycle on.
- R9: Storage slots are reused modulo `DEPTH`. After releases, nodes with index at or above `DEPTH` hit with their own data, and the older node that shared the slot misses.
- R10: A read in the same cycle as a release sees the window as it stood before that release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Offer a node value at the tail |
| wr_data | input | DATA_W | Node value offered |
| wr_ready | output | 1 | Window has a free slot |
| rel_req | input | 1 | Release the lowest-indexed chunk |
| rd_valid | input | 1 | Issue a read |
| rd_index | input | IDX_W | Absolute node index to read |
| rd_out_valid | output | 1 | Read result present (one cycle after issue) |
| rd_hit | output | 1 | Index was inside the window |
| rd_data | output | DATA_W | Node value on hit, zero on miss |
| win_base | output | IDX_W | Lowest node index held |
| win_count | output | $clog2(DEPTH)+1 | Words currently held |

## Verification
The hardest situation to reach is slot reuse. Node indices must pass `DEPTH`, so a node and an older node that shared its slot must coexist in the index space while only one of them is in the window. The stimulus gets there in stages. It fills the window to the stall, tries a write that must be dropped, then releases one chunk and writes the next node. That node lands in a slot that held a released node. Reads of both indices then separate a correct modulo mapping from a stale one. The same-cycle cases (a write and a read of that index, a release and a read of the oldest chunk) are driven in single cycles so the pre-edge view of the window is what gets checked.

// File: rtl/swin_pkg.sv
package swin_pkg;
    typedef enum logic [1:0] {
        W_EMPTY   = 2'd0,
        W_PARTIAL = 2'd1,
        W_FULL    = 2'd2
    } win_state_t;
endpackage

// File: rtl/swin_store.sv
module swin_store #(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // registered read port: returns the contents before a same-edge write
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/swin_lookup.sv
module swin_lookup #(
    parameter int IDX_W = 32,
    parameter int CNT_W = 11
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] base,
    input  logic [CNT_W-1:0] count,
    output logic             hit
);
    logic [IDX_W-1:0] offset;

    // a single unsigned compare covers both bounds, also across index wrap
    always_comb begin
        offset = idx - base;
        hit    = offset < IDX_W'(count);
    end
endmodule

// File: rtl/swin_ctrl.sv
module swin_ctrl
    import swin_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int CHUNK = 16,
    parameter int IDX_W = 32,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic             rel_req,
    output logic             wr_ready,
    output logic             wr_fire,
    output logic [IDX_W-1:0] base,
    output logic [CNT_W-1:0] count
);
    win_state_t       state, state_nxt;
    logic             rel_fire;
    logic [CNT_W-1:0] count_nxt;

    always_comb begin
        wr_fire   = wr_valid && wr_ready;
        rel_fire  = rel_req && (count >= CNT_W'(CHUNK));
        count_nxt = count + {{(CNT_W-1){1'b0}}, wr_fire}
                          - (rel_fire ? CNT_W'(CHUNK) : '0);
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            W_EMPTY: begin
                if (wr_fire) state_nxt = W_PARTIAL;          // fill_start
            end
            W_PARTIAL: begin
                if (count_nxt == '0)                 state_nxt = W_EMPTY; // drain_empty
                else if (count_nxt == CNT_W'(DEPTH)) state_nxt = W_FULL;  // fill_top
            end
            W_FULL: begin
                if (rel_fire) state_nxt = (count_nxt == '0) ? W_EMPTY : W_PARTIAL; // release_from_full
            end
            default: state_nxt = W_EMPTY;
        endcase
    end

    // state register together with the window bookkeeping it governs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= W_EMPTY;
            base  <= '0;
            count <= '0;
        end else begin
            state <= state_nxt;
            count <= count_nxt;
            if (rel_fire) base <= base + IDX_W'(CHUNK);
        end
    end

    // outputs decoded from the state alone
    always_comb begin
        unique case (state)
            W_FULL:  wr_ready = 1'b0;
            default: wr_ready = 1'b1;
        endcase
    end
endmodule

// File: rtl/swin_fifo.sv
module swin_fifo #(
    parameter int DEPTH  = 1024,
    parameter int CHUNK  = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              rel_req,
    input  logic              rd_valid,
    input  logic [IDX_W-1:0]  rd_index,
    output logic              rd_out_valid,
    output logic              rd_hit,
    output logic [DATA_W-1:0] rd_data,
    output logic [IDX_W-1:0]  win_base,
    output logic [CNT_W-1:0]  win_count
);
    logic              wr_fire;
    logic              hit_now;
    logic [AW-1:0]     tail_slot;
    logic [DATA_W-1:0] mem_q;

    swin_ctrl #(.DEPTH(DEPTH), .CHUNK(CHUNK), .IDX_W(IDX_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .rel_req  (rel_req),
        .wr_ready (wr_ready),
        .wr_fire  (wr_fire),
        .base     (win_base),
        .count    (win_count)
    );

    swin_lookup #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_lookup (
        .idx   (rd_index),
        .base  (win_base),
        .count (win_count),
        .hit   (hit_now)
    );

    // node i lives in slot i mod DEPTH
    assign tail_slot = win_base[AW-1:0] + win_count[AW-1:0];

    swin_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .we    (wr_fire),
        .waddr (tail_slot),
        .wdata (wr_data),
        .raddr (rd_index[AW-1:0]),
        .rdata (mem_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_out_valid <= 1'b0;
            rd_hit       <= 1'b0;
        end else begin
            rd_out_valid <= rd_valid;
            rd_hit       <= rd_valid && hit_now;
        end
    end

    assign rd_data = rd_hit ? mem_q : '0;
endmodule

// File: rtl/swin_chk.sv
module swin_chk #(
    parameter int DEPTH  = 1024,
    parameter int CHUNK  = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 32,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic              rel_req,
    input logic              rd_valid,
    input logic              rd_out_valid,
    input logic              rd_hit,
    input logic [DATA_W-1:0] rd_data,
    input logic [IDX_W-1:0]  win_base,
    input logic [CNT_W-1:0]  win_count
);
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        win_count <= CNT_W'(DEPTH));

    a_r3_stall_full: assert property (@(posedge clk) disable iff (!rst_n)
        (win_count == CNT_W'(DEPTH)) |-> !wr_ready);

    a_r2_grow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && !rel_req) |=> win_count == $past(win_count) + 1'b1);

    a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rd_out_valid);

    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> !rd_out_valid);

    a_r5_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_out_valid && !rd_hit) |-> rd_data == '0);

    a_r6_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_req && win_count >= CNT_W'(CHUNK)) |=> win_base == $past(win_base) + IDX_W'(CHUNK));

    a_r7_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_req && win_count < CNT_W'(CHUNK)) |=> $stable(win_base));
endmodule

bind swin_fifo swin_chk #(
    .DEPTH(DEPTH), .CHUNK(CHUNK), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_swin_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .rel_req      (rel_req),
    .rd_valid     (rd_valid),
    .rd_out_valid (rd_out_valid),
    .rd_hit       (rd_hit),
    .rd_data      (rd_data),
    .win_base     (win_base),
    .win_count    (win_count)
);

// File: tb/test_swin_fifo.sv
`timescale 1ns/1ps
module test_swin_fifo;
    localparam int DEPTH  = 1024;
    localparam int CHUNK  = 16;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 32;
    localparam int CNT_W  = $clog2(DEPTH) + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              wr_ready;
    logic              rel_req = 1'b0;
    logic              rd_valid = 1'b0;
    logic [IDX_W-1:0]  rd_index = '0;
    logic              rd_out_valid;
    logic              rd_hit;
    logic [DATA_W-1:0] rd_data;
    logic [IDX_W-1:0]  win_base;
    logic [CNT_W-1:0]  win_count;

    always #2.5 clk = ~clk;

    swin_fifo #(.DEPTH(DEPTH), .CHUNK(CHUNK), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_swin_fifo (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .rel_req(rel_req), .rd_valid(rd_valid), .rd_index(rd_index),
        .rd_out_valid(rd_out_valid), .rd_hit(rd_hit), .rd_data(rd_data),
        .win_base(win_base), .win_count(win_count)
    );

    typedef struct {
        logic        hit;
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   mbase = 0;
    int   mcount = 0;
    bit   done = 0;

    function automatic logic [31:0] pat(int i);
        return i * 32'h9E3779B1 + 32'h01234567;
    endfunction

    // monitor: compares read results against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && rd_out_valid) begin
            n_chk++;
            if (q.size() == 0) begin
                n_bad++;
                $display("FAIL R4 unexpected result: got hit=%0b exp none", rd_hit);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (rd_hit !== e.hit || rd_data !== e.data) begin
                    n_bad++;
                    $display("FAIL %s: got hit=%0b data=%h exp hit=%0b data=%h",
                             e.tag, rd_hit, rd_data, e.hit, e.data);
                end
            end
        end
    end

    // driver: one cycle of stimulus, model updated with the pre-edge window
    task automatic step(bit do_wr, bit do_rd, int idx, bit do_rel, string tag);
        exp_t e;
        int   old_count;
        @(negedge clk);
        wr_valid = do_wr;
        wr_data  = pat(mbase + mcount);
        rd_valid = do_rd;
        rd_index = idx;
        rel_req  = do_rel;
        if (do_wr) begin
            n_chk++;
            if (wr_ready !== (mcount < DEPTH)) begin
                n_bad++;
                $display("FAIL R3 wr_ready: got %0b exp %0b", wr_ready, mcount < DEPTH);
            end
        end
        if (do_rd) begin
            e.hit  = (idx >= mbase) && (idx < mbase + mcount);
            e.data = e.hit ? pat(idx) : 32'h0;
            e.tag  = tag;
            q.push_back(e);
        end
        old_count = mcount;
        if (do_wr && mcount < DEPTH) mcount++;
        if (do_rel && old_count >= CHUNK) begin
            mbase  += CHUNK;
            mcount -= CHUNK;
        end
    endtask

    task automatic idle();
        @(negedge clk);
        wr_valid = 0; rd_valid = 0; rel_req = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: empty after reset
        @(negedge clk);
        n_chk++;
        if (wr_ready !== 1'b1) begin
            n_bad++;
            $display("FAIL R1 wr_ready: got %0b exp 1", wr_ready);
        end
        step(0, 1, 0, 0, "R1 read after reset");
        // R2 fill 40 nodes
        for (int k = 0; k < 40; k++) step(1, 0, 0, 0, "R2");
        idle();
        step(0, 1, 0, 0, "R4 first node hit");
        step(0, 1, 39, 0, "R4 last node hit");
        step(0, 1, 40, 0, "R5 beyond tail miss");
        step(0, 1, 32'h7000_0000, 0, "R5 far index miss");
        // R8: same-cycle write and read of node 40
        step(1, 1, 40, 0, "R8 same-cycle read misses");
        step(0, 1, 40, 0, "R8 next-cycle read hits");
        // R6: release one chunk, base 16 count 25
        step(0, 0, 0, 1, "R6");
        step(0, 1, 15, 0, "R6 released node misses");
        step(0, 1, 16, 0, "R6 new base hits");
        // R10: read oldest chunk while releasing it
        step(0, 1, 16, 1, "R10 read during release sees old window");
        step(0, 1, 16, 0, "R6 second release node misses");
        // R7: count 9 < CHUNK, release ignored
        step(0, 0, 0, 1, "R7");
        step(0, 1, 32, 0, "R7 ignored release keeps base");
        step(0, 1, 40, 0, "R7 ignored release keeps tail");
        // R3: fill to capacity
        while (mcount < DEPTH) step(1, 0, 0, 0, "R3");
        step(1, 0, 0, 0, "R3 dropped write");
        idle();
        step(0, 1, mbase + DEPTH, 0, "R3 dropped write not stored");
        step(0, 1, mbase + DEPTH - 1, 0, "R9 newest node hits");
        step(0, 1, DEPTH, 0, "R9 index at depth hits");
        step(0, 1, 32, 0, "R9 base node still hits");
        // R9: release, write node that reuses slot of node 32
        step(0, 0, 0, 1, "R9");
        step(1, 0, 0, 0, "R9 write after release");
        idle();
        step(0, 1, 1056, 0, "R9 reused slot new node hits");
        step(0, 1, 32, 0, "R9 old node in slot misses");
        step(0, 1, 47, 0, "R6 released node misses");
        step(0, 1, 48, 0, "R9 base after release hits");
        idle();
        repeat (3) @(negedge clk);
        n_chk++;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R4 pending results: got %0d exp 0", q.size());
        end
        finish_run();
    end
endmodule